// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a hardware master that fetches 16-bit words from a three-wire serial configuration EEPROM. The EEPROM is assumed to use 8-bit word addressing and a read opcode of `110`. A client supplies four things with a one-cycle start pulse: a starting word address, a word count, a byte-swap flag and a settle-delay length in system clocks. The block then reads the words one at a time from consecutive addresses and hands each word back with a one-cycle valid strobe. A busy flag covers the whole request.

Every line change on the device side is followed by a settle period of the programmed length. Each word goes through the same steps:

1. A flush sequence that clocks the part 25 times with chip select held, which brings it back to a known state.
2. A short entry into access mode.
3. An 11-bit command that carries the opcode and the address.
4. Sixteen data bits, read most significant bit first.
5. A second flush.

The block has no storage for the words. The client must take each word in the cycle its strobe is high.

Top module: `eeword_rdr`

## Requirements
- R1: During and after reset, with no request, `busy`, `word_valid`, `ee_cs`, `ee_sk` and `ee_di` are all low.
- R2: A start pulse is accepted only when `busy` is low and `req_count` is non-zero. `busy` goes high on the clock edge that samples it. `busy` stays high up to and including the cycle of the last `word_valid`, and is low in the next cycle. A start pulse that arrives while busy, or with a count of zero, has no effect.
- R3: Every device-line state is held for exactly N clocks. N is `settle_cyc` as sampled at the accepted start, with a value of 0 treated as 1. Changing `settle_cyc` during a request has no effect on that request.
- R4: Before each word a flush runs with `ee_di` low throughout. Its states are: chip select high with clock low; clock high; 25 pairs of clock low then clock high; clock low; then chip select low.
- R5: After the flush, access mode is entered with chip select high and clock low, followed by clock high.
- R6: The command is the 11-bit value {3'b110, address[7:0]}, sent most significant bit first. Each bit takes three states: clock low with the new data on `ee_di`, clock high, clock low. `ee_di` never changes while `ee_sk` is high.
- R7: Sixteen data bits follow, most significant bit first. Each bit takes three states: clock high, clock high, clock low. `ee_do` is sampled at the end of the first high state. `ee_di` keeps the last command bit during this part.
- R8: After the data bits the same flush as R4 runs again. It is followed by one cycle with all device lines low and `word_valid` high.
- R9: Word k of a request, counting from 0, is read from address (`req_addr` + k) modulo 256.
- R10: With `req_swap` set, the delivered word has its two bytes exchanged, `{data[7:0], data[15:8]}`. Otherwise it is delivered as read.
- R11: `word_valid` is a single-cycle pulse, only while `busy` is high and `ee_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request pulse |
| req_addr | input | ADDR_W | First word address |
| req_count | input | CNT_W | Number of words to read |
| req_swap | input | 1 | Exchange the two bytes of each word |
| settle_cyc | input | DLY_W | Clocks per device-line state (0 acts as 1) |
| busy | output | 1 | Request in progress |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_data | output | DATA_W | Word just read |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench attaches a behavioural serial EEPROM. The model ignores zeros until it sees a start bit, then decodes the opcode and the address and shifts data out on each clock rise. The bench compares every device line, the busy flag and the valid strobe against a cycle-exact expected schedule, so an off-by-one in the flush pulse count, a settle period of the wrong length, or a sample taken in the low half of the clock shows up as a line mismatch or a wrong word. The corner cases covered are:

- An address run that wraps past 0xFF. A design that carries the address into the opcode bits would make the model return zeros.
- A settle value of zero. An underflowing counter would stretch each state to 256 clocks.
- A second start pulse, with a new settle value, arriving mid-request. A design that re-latches them would change the address and the timing of the words still to come.
- A zero count. A design that accepts it would start a request that never ends.

// File: rtl/eeword_pkg.sv
package eeword_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_PRE,
      SQ_ENTER,
      SQ_CMD,
      SQ_READ,
      SQ_POST,
      SQ_DELIVER
   } sq_state_t;

   typedef struct packed {
      logic cs;
      logic sk;
      logic di;
   } line_t;

   // last of the three sub-states used per command or data bit
   localparam logic [1:0] SUB_LAST = 2'd2;

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eeword_tick.sv
// Settle-delay counter: each load starts a window of dly clocks (0 acts as 1).
module eeword_tick #(
   parameter int unsigned DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] dly,
   output logic             expire
);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (dly == '0) ? '0 : dly - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == '0);

endmodule

// File: rtl/eeword_swap.sv
// Byte-order reversal of a word, selected at run time.
module eeword_swap #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] din,
   input  logic              en,
   output logic [DATA_W-1:0] dout
);

   localparam int unsigned NBYTES = DATA_W / 8;

   logic [DATA_W-1:0] rev;

   generate
      if (NBYTES < 2) begin : g_single
         assign rev = din;
      end else begin : g_multi
         for (genvar i = 0; i < NBYTES; i++) begin : g_byte
            assign rev[8*i +: 8] = din[DATA_W-8*(i+1) +: 8];
         end
      end
   endgenerate

   assign dout = en ? rev : din;

endmodule

// File: rtl/eeword_seq.sv
// Per-word sequencer: flush, access entry, command shift, data shift, flush.
module eeword_seq
   import eeword_pkg::*;
#(
   parameter int unsigned FLUSH_PULSES = 25,
   parameter int unsigned CMD_W        = 11,
   parameter int unsigned DATA_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              more,
   input  logic              expire,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic              ee_do,
   output logic              load,
   output logic              fin,
   output logic              advance_word,
   output logic              busy,
   output line_t             lines,
   output logic [DATA_W-1:0] shreg
);

   localparam int unsigned FL_LAST = 2 * FLUSH_PULSES + 3;
   localparam int unsigned IW      = $clog2(FL_LAST + 1);
   localparam int unsigned BW      = $clog2(max2(CMD_W, DATA_W));
   localparam logic [IW-1:0] FL_END  = IW'(FL_LAST);
   localparam logic [BW-1:0] CMD_END = BW'(CMD_W - 1);
   localparam logic [BW-1:0] DAT_END = BW'(DATA_W - 1);

   sq_state_t   st_q, st_d;
   logic [IW-1:0] ix_q, ix_d;
   logic [BW-1:0] bt_q, bt_d;
   logic [1:0]    sb_q, sb_d;
   logic          smp;
   line_t         ln_d;

   // next-state: one step per settle-window expiry
   always_comb begin
      st_d         = st_q;
      ix_d         = ix_q;
      bt_d         = bt_q;
      sb_d         = sb_q;
      load         = 1'b0;
      fin          = 1'b0;
      advance_word = 1'b0;
      smp          = 1'b0;
      unique case (st_q)
         SQ_IDLE: begin
            if (go) begin
               st_d = SQ_PRE;
               ix_d = '0;
               load = 1'b1;
            end
         end
         SQ_PRE, SQ_POST: begin
            if (expire) begin
               if (ix_q == FL_END) begin
                  ix_d = '0;
                  if (st_q == SQ_PRE) begin
                     st_d = SQ_ENTER;
                     load = 1'b1;
                  end else begin
                     st_d = SQ_DELIVER;
                     fin  = 1'b1;
                  end
               end else begin
                  ix_d = ix_q + 1'b1;
                  load = 1'b1;
               end
            end
         end
         SQ_ENTER: begin
            if (expire) begin
               load = 1'b1;
               if (ix_q == '0) begin
                  ix_d = IW'(1);
               end else begin
                  st_d = SQ_CMD;
                  ix_d = '0;
                  bt_d = '0;
                  sb_d = '0;
               end
            end
         end
         SQ_CMD, SQ_READ: begin
            if (expire) begin
               load = 1'b1;
               smp  = (st_q == SQ_READ) && (sb_q == 2'd0);
               if (sb_q != SUB_LAST) begin
                  sb_d = sb_q + 1'b1;
               end else begin
                  sb_d = '0;
                  if (bt_q == ((st_q == SQ_CMD) ? CMD_END : DAT_END)) begin
                     bt_d = '0;
                     ix_d = '0;
                     st_d = (st_q == SQ_CMD) ? SQ_READ : SQ_POST;
                  end else begin
                     bt_d = bt_q + 1'b1;
                  end
               end
            end
         end
         SQ_DELIVER: begin
            if (more) begin
               st_d         = SQ_PRE;
               ix_d         = '0;
               load         = 1'b1;
               advance_word = 1'b1;
            end else begin
               st_d = SQ_IDLE;
            end
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   // device-line levels for the step being entered
   always_comb begin
      ln_d = '0;
      unique case (st_d)
         SQ_PRE, SQ_POST: begin
            ln_d.cs = (ix_d != FL_END);
            ln_d.sk = ix_d[0] && (ix_d != FL_END);
         end
         SQ_ENTER: begin
            ln_d.cs = 1'b1;
            ln_d.sk = ix_d[0];
         end
         SQ_CMD: begin
            ln_d.cs = 1'b1;
            ln_d.sk = (sb_d == 2'd1);
            ln_d.di = cmd_word[CMD_END - bt_d];
         end
         SQ_READ: begin
            ln_d.cs = 1'b1;
            ln_d.sk = (sb_d != SUB_LAST);
            ln_d.di = cmd_word[0];
         end
         default: ln_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         ix_q  <= '0;
         bt_q  <= '0;
         sb_q  <= '0;
         lines <= '0;
         shreg <= '0;
      end else begin
         st_q  <= st_d;
         ix_q  <= ix_d;
         bt_q  <= bt_d;
         sb_q  <= sb_d;
         lines <= ln_d;
         if (smp) begin
            shreg <= {shreg[DATA_W-2:0], ee_do};
         end
      end
   end

   assign busy = (st_q != SQ_IDLE);

endmodule

// File: rtl/eeword_rdr.sv
// Top: request capture, address and count tracking, word output register.
module eeword_rdr
   import eeword_pkg::*;
#(
   parameter int unsigned     ADDR_W       = 8,
   parameter int unsigned     OP_W         = 3,
   parameter logic [OP_W-1:0] OPCODE       = 3'b110,
   parameter int unsigned     DATA_W       = 16,
   parameter int unsigned     CNT_W        = 8,
   parameter int unsigned     DLY_W        = 8,
   parameter int unsigned     FLUSH_PULSES = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CNT_W-1:0]  req_count,
   input  logic              req_swap,
   input  logic [DLY_W-1:0]  settle_cyc,
   output logic              busy,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_data,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);

   localparam int unsigned CMD_W = OP_W + ADDR_W;

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data_w
         $error("eeword_rdr: DATA_W must be a whole, non-zero number of bytes");
      end
      if (ADDR_W < 1 || OP_W < 1) begin : g_bad_cmd_w
         $error("eeword_rdr: ADDR_W and OP_W must be at least 1");
      end
      if (CNT_W < 1 || DLY_W < 1) begin : g_bad_ctr_w
         $error("eeword_rdr: CNT_W and DLY_W must be at least 1");
      end
      if (FLUSH_PULSES < 1) begin : g_bad_flush
         $error("eeword_rdr: FLUSH_PULSES must be at least 1");
      end
   endgenerate

   logic              go, more, load, fin, adv, expire;
   line_t             lines;
   logic [DATA_W-1:0] sh_word, sw_word;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic              swap_q;
   logic [DLY_W-1:0]  dly_q, dly_sel;
   logic [CMD_W-1:0]  cmd_word;

   assign go       = req_start && !busy && (req_count != '0);
   assign more     = (left_q != CNT_W'(1));
   assign dly_sel  = go ? settle_cyc : dly_q;
   assign cmd_word = {OPCODE, addr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
         swap_q <= 1'b0;
         dly_q  <= '0;
      end else if (go) begin
         addr_q <= req_addr;
         left_q <= req_count;
         swap_q <= req_swap;
         dly_q  <= settle_cyc;
      end else if (adv) begin
         addr_q <= addr_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   eeword_tick #(
      .DLY_W (DLY_W)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .dly    (dly_sel),
      .expire (expire)
   );

   eeword_seq #(
      .FLUSH_PULSES (FLUSH_PULSES),
      .CMD_W        (CMD_W),
      .DATA_W       (DATA_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .go           (go),
      .more         (more),
      .expire       (expire),
      .cmd_word     (cmd_word),
      .ee_do        (ee_do),
      .load         (load),
      .fin          (fin),
      .advance_word (adv),
      .busy         (busy),
      .lines        (lines),
      .shreg        (sh_word)
   );

   eeword_swap #(
      .DATA_W (DATA_W)
   ) u_swap (
      .din  (sh_word),
      .en   (swap_q),
      .dout (sw_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_valid <= 1'b0;
         word_data  <= '0;
      end else begin
         word_valid <= fin;
         if (fin) begin
            word_data <= sw_word;
         end
      end
   end

   assign ee_cs = lines.cs;
   assign ee_sk = lines.sk;
   assign ee_di = lines.di;

endmodule

// File: rtl/eeword_rdr_chk.sv
module eeword_rdr_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_start,
   input logic [CNT_W-1:0] req_count,
   input logic             busy,
   input logic             word_valid,
   input logic             ee_cs,
   input logic             ee_sk,
   input logic             ee_di
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ee_cs && !ee_sk && !ee_di && !word_valid));

   assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_start && (req_count != '0)));

   assert_busy_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(word_valid));

   assert_clock_needs_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs);

   assert_data_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ee_di) |-> !ee_sk);

   assert_valid_context_R11: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (busy && !ee_cs));

   assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

endmodule

bind eeword_rdr eeword_rdr_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_start  (req_start),
   .req_count  (req_count),
   .busy       (busy),
   .word_valid (word_valid),
   .ee_cs      (ee_cs),
   .ee_sk      (ee_sk),
   .ee_di      (ee_di)
);

// File: tb/eeword_rdr_tb.sv
module eeword_rdr_tb;

   localparam int NP = 25;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [7:0]  req_count = '0;
   logic        req_swap = 1'b0;
   logic [7:0]  settle_cyc = '0;
   logic        busy, word_valid, ee_cs, ee_sk, ee_di;
   logic [15:0] word_data;
   logic        ee_do = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   eeword_rdr u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_start  (req_start),
      .req_addr   (req_addr),
      .req_count  (req_count),
      .req_swap   (req_swap),
      .settle_cyc (settle_cyc),
      .busy       (busy),
      .word_valid (word_valid),
      .word_data  (word_data),
      .ee_cs      (ee_cs),
      .ee_sk      (ee_sk),
      .ee_di      (ee_di),
      .ee_do      (ee_do)
   );

   // ---------------- behavioural serial EEPROM ----------------
   function automatic logic [15:0] rom_word(logic [7:0] a);
      return {a ^ 8'h5A, (~a) + 8'd3};
   endfunction

   int          dv_st = 0;
   int          dv_n = 0;
   logic [9:0]  dv_sh = '0;
   logic [15:0] dv_w = '0;

   always @(posedge ee_sk or negedge ee_cs) begin
      if (!ee_cs) begin
         dv_st = 0;
         dv_n  = 0;
         ee_do = 1'b0;
      end else begin
         case (dv_st)
            0: if (ee_di) begin dv_st = 1; dv_n = 0; end
            1: begin
               dv_sh = {dv_sh[8:0], ee_di};
               dv_n++;
               if (dv_n == 10) begin
                  dv_st = 2;
                  dv_n  = 0;
                  dv_w  = (dv_sh[9:8] == 2'b10) ? rom_word(dv_sh[7:0]) : 16'h0000;
               end
            end
            2: begin
               ee_do = dv_w[15-dv_n];
               dv_n++;
               if (dv_n == 16) dv_st = 3;
            end
            default: ee_do = 1'b0;
         endcase
      end
   end

   // ---------------- expected schedule ----------------
   typedef struct packed {
      logic b;
      logic cs;
      logic sk;
      logic di;
      logic v;
   } exp_t;

   exp_t        eq[$];
   string       tq[$];
   logic [15:0] dq[$];

   task automatic check(string tag, bit ok, string what, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic ph(logic cs, logic sk, logic di, int n, string tag);
      for (int k = 0; k < n; k++) begin
         eq.push_back({1'b1, cs, sk, di, 1'b0});
         tq.push_back(tag);
      end
   endtask

   task automatic flush(int d, string tag);
      ph(1'b1, 1'b0, 1'b0, d, tag);
      ph(1'b1, 1'b1, 1'b0, d, tag);
      for (int k = 0; k < NP; k++) begin
         ph(1'b1, 1'b0, 1'b0, d, tag);
         ph(1'b1, 1'b1, 1'b0, d, tag);
      end
      ph(1'b1, 1'b0, 1'b0, d, tag);
      ph(1'b0, 1'b0, 1'b0, d, tag);
   endtask

   task automatic word_plan(logic [7:0] a, int d, logic sw, bit later);
      logic [10:0] c;
      logic [15:0] w;
      c = {3'b110, a};
      flush(d, "R4");
      ph(1'b1, 1'b0, 1'b0, d, "R5");
      ph(1'b1, 1'b1, 1'b0, d, "R5");
      for (int j = 10; j >= 0; j--) begin
         ph(1'b1, 1'b0, c[j], d, "R6");
         ph(1'b1, 1'b1, c[j], d, "R6");
         ph(1'b1, 1'b0, c[j], d, "R6");
      end
      for (int j = 0; j < 16; j++) begin
         ph(1'b1, 1'b1, c[0], d, "R7");
         ph(1'b1, 1'b1, c[0], d, "R7");
         ph(1'b1, 1'b0, c[0], d, "R7");
      end
      flush(d, "R8");
      w = rom_word(a);
      if (sw) w = {w[7:0], w[15:8]};
      eq.push_back({1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
      tq.push_back(later ? "R9" : (sw ? "R10" : "R8"));
      dq.push_back(w);
   endtask

   task automatic run_req(logic [7:0] a, int n, logic sw, int dly_in, int poke_at);
      int   d;
      int   idx;
      int   busy_cyc;
      int   pulses;
      bit   bad;
      exp_t e;
      exp_t got;
      string tg;
      logic [15:0] ew;
      d = (dly_in == 0) ? 1 : dly_in;
      idx = 0; busy_cyc = 0; pulses = 0; bad = 0;
      for (int k = 0; k < n; k++) word_plan(a + 8'(k), d, sw, k > 0);
      @(negedge clk);
      req_addr = a; req_count = 8'(n); req_swap = sw; settle_cyc = 8'(dly_in); req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      while (eq.size() > 0) begin
         e  = eq.pop_front();
         tg = tq.pop_front();
         if (idx == poke_at) begin
            // R2 / R3: start and new settle value while busy must be ignored
            req_start = 1'b1; req_addr = ~a; req_swap = ~sw;
            settle_cyc = 8'(dly_in + 4); req_count = 8'd3;
         end else if (idx == poke_at + 1) begin
            req_start = 1'b0;
         end
         if (busy) busy_cyc++;
         if (word_valid) pulses++;
         if (!bad) begin
            got = {busy, ee_cs, ee_sk, ee_di, word_valid};
            check(tg, got === e, "lines{busy,cs,sk,di,valid}", 32'(got), 32'(e));
            if (got !== e) bad = 1;
            else if (e.v) begin
               ew = dq.pop_front();
               check(tg, word_data === ew, "word_data", 32'(word_data), 32'(ew));
            end
         end
         idx++;
         @(negedge clk);
      end
      dq.delete();
      check("R2", busy === 1'b0 && ee_cs === 1'b0 && word_valid === 1'b0,
            "idle after last word", {29'd0, busy, ee_cs, word_valid}, 32'd0);
      check("R3", busy_cyc == n * (191 * d + 1), "busy cycles", 32'(busy_cyc), 32'(n * (191 * d + 1)));
      check("R11", pulses == n, "valid pulse count", 32'(pulses), 32'(n));
      for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      check("R1", busy === 1'b0 && ee_cs === 1'b0 && ee_sk === 1'b0 && ee_di === 1'b0 && word_valid === 1'b0,
            "lines in reset", {27'd0, busy, ee_cs, ee_sk, ee_di, word_valid}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", busy === 1'b0 && ee_cs === 1'b0 && ee_sk === 1'b0 && ee_di === 1'b0 && word_valid === 1'b0,
            "lines after reset", {27'd0, busy, ee_cs, ee_sk, ee_di, word_valid}, 32'd0);

      // R2: zero count is ignored
      req_count = 8'd0; req_addr = 8'h33; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      check("R2", busy === 1'b0 && ee_cs === 1'b0, "zero count start", {30'd0, busy, ee_cs}, 32'd0);
      repeat (3) @(negedge clk);
      check("R2", busy === 1'b0 && ee_sk === 1'b0, "zero count later", {30'd0, busy, ee_sk}, 32'd0);

      run_req(8'h12, 1, 1'b0, 2, -10);   // R4..R8 single word
      run_req(8'hFE, 3, 1'b1, 0, -10);   // R9 wrap, R10 swap, R3 zero settle
      run_req(8'h40, 2, 1'b0, 3, 500);   // R2/R3 start while busy ignored
      run_req(8'hA7, 1, 1'b1, 5, -10);   // R10 swap, longer settle

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule